// File: doc/BRIEF.md
# Processor Power-Mode Controller

This block sits beside a small processor core and decides, cycle by cycle, whether the core's clock runs, whether the oscillator runs, and which power mode the part is in. The core reports when it executes a halt instruction or a stop instruction. An interrupt request and a watchdog expiry come in from the always-clocked timer and interrupt logic. The block answers with a CPU clock enable, an oscillator enable, a two-bit mode code and two one-cycle pulses. One pulse tells the core to continue with the instruction after the one that put it to sleep. The other tells it to restart from the fixed restart vector, address 0x0020.

Halt gates only the core's clock. The oscillator keeps running, so timers and interrupt logic keep counting. Stop turns off the oscillator as well, but only when the core has opted in. A stop-inhibit flag is set by reset, and while it is set a stop instruction does nothing. The flag can be changed only during a short window of clock-enabled cycles right after reset. Every wake from stop sets the flag again.

Leaving stop, or leaving reset, the oscillator comes on at once. The CPU clock stays off for a programmable settle time, so the core never runs on an unsettled clock.

Top module: `pwrmode_ctrl`

## Requirements
- R1: While `rst` is high, `osc_en` is 1, `cpu_clk_en` is 0 and `mode` is 00. After release, `cpu_clk_en` stays 0 for exactly SETTLE_CYCLES clock edges. It then rises with a one-cycle `restart_vec` pulse.
- R2: In run mode (`mode` 00, `cpu_clk_en` 1), `halt_req` without `wdt_expire` gives `mode` 01 and `cpu_clk_en` 0 after the next edge, with `osc_en` still 1. `halt_req` wins over a simultaneous `stop_req`.
- R3: In halt mode, `irq` without `wdt_expire` gives `mode` 00 and `cpu_clk_en` 1 after the next edge, with `resume_next` high for that one cycle.
- R4: In halt mode, `wdt_expire` (with or without `irq`) returns to run after the next edge. `restart_vec` pulses and `resume_next` stays 0.
- R5: While the stop-inhibit flag is set, `stop_req` in run mode has no effect: `mode` stays 00 and `cpu_clk_en` stays 1.
- R6: Reset sets the stop-inhibit flag. A `cfg_wr` in one of the first WIN_CYCLES clock-enabled cycles after reset loads the flag from `cfg_stop_dis`. A `cfg_wr` at any later time is ignored.
- R7: With the flag clear, `stop_req` in run mode gives `mode` 10, `osc_en` 0 and `cpu_clk_en` 0 after the next edge.
- R8: In stop mode, `irq` or `wdt_expire` sets `osc_en` to 1 after the next edge, with `mode` still 10. `cpu_clk_en` then stays 0 for SETTLE_CYCLES edges counted from that point, then returns with `mode` 00. The return carries a `resume_next` pulse for `irq`, or a `restart_vec` pulse if `wdt_expire` was present (the watchdog wins).
- R9: Every wake from stop sets the stop-inhibit flag again, so a following `stop_req` has no effect.
- R10: `wdt_expire` in run mode pulses `restart_vec` after the next edge, and `cpu_clk_en` stays 1.
- R11: While `cpu_clk_en` is 0, `halt_req`, `stop_req` and `cfg_wr` are ignored. `mode` 01 stays 01 under a `stop_req`.
- R12: `mode` never reads 11, `resume_next` and `restart_vec` are never high together, and `cpu_clk_en` is never 1 while `osc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Core executed a halt instruction |
| stop_req | input | 1 | Core executed a stop instruction |
| irq | input | 1 | Pending interrupt request |
| wdt_expire | input | 1 | Watchdog timeout |
| cfg_wr | input | 1 | Write strobe for the stop-inhibit flag |
| cfg_stop_dis | input | 1 | Value to load into the stop-inhibit flag |
| cpu_clk_en | output | 1 | Enable for the gated CPU clock |
| osc_en | output | 1 | Enable for the oscillator |
| mode | output | 2 | 00 run, 01 halt, 10 stop (also while settling out of stop) |
| resume_next | output | 1 | One-cycle pulse: continue after the sleeping instruction |
| restart_vec | output | 1 | One-cycle pulse: restart at address 0x0020 |

## Verification
A corrupted mode state shows at `cpu_clk_en`, `osc_en` and `mode` in the very cycle after the edge that corrupted it, because these outputs decode the state register directly. A wrong settle count shows only as a shifted rise of `cpu_clk_en`, up to SETTLE_CYCLES edges after the wake event. A wrong stop-inhibit flag stays hidden until the next `stop_req`, which then either parks the part or falls through as a no-op one edge later. A wrong wake cause shows as the wrong pulse in the first clock-enabled cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [2:0] {
        ST_BOOT = 3'd0,
        ST_RUN  = 3'd1,
        ST_HALT = 3'd2,
        ST_STOP = 3'd3,
        ST_WAKE = 3'd4
    } pm_state_t;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_HALT = 2'b01,
        MODE_STOP = 2'b10
    } pm_mode_t;

    typedef enum logic [1:0] {
        CAUSE_RST = 2'd0,
        CAUSE_IRQ = 2'd1,
        CAUSE_WDT = 2'd2
    } pm_cause_t;

    typedef struct packed {
        logic cpu_clk_en;
        logic osc_en;
        pm_mode_t mode;
    } pm_outs_t;

    function automatic pm_outs_t decode_state(pm_state_t st);
        pm_outs_t o;
        o.cpu_clk_en = (st == ST_RUN);
        o.osc_en     = (st != ST_STOP);
        case (st)
            ST_HALT:          o.mode = MODE_HALT;
            ST_STOP, ST_WAKE: o.mode = MODE_STOP;
            default:          o.mode = MODE_RUN;
        endcase
        return o;
    endfunction

    function automatic logic is_settling(pm_state_t st);
        return (st == ST_BOOT) || (st == ST_WAKE);
    endfunction

endpackage

// File: rtl/pm_settle_cnt.sv
module pm_settle_cnt #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic counting,
    output logic done
);
    localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!counting) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = counting && (cnt_q == LAST);
endmodule

// File: rtl/pm_stop_cfg.sv
module pm_stop_cfg #(
    parameter int WIN_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic cfg_wr,
    input  logic cfg_val,
    input  logic stop_wake,
    output logic stop_dis
);
    localparam int WW = $clog2(WIN_CYCLES + 1);
    localparam logic [WW-1:0] WLIM = WW'(WIN_CYCLES);

    logic [WW-1:0] win_q;
    logic          win_open;
    logic          dis_q;

    assign win_open = (win_q != WLIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (run_en && win_open) begin
            win_q <= win_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q <= 1'b1;
        end else if (stop_wake) begin
            dis_q <= 1'b1;
        end else if (cfg_wr && run_en && win_open) begin
            dis_q <= cfg_val;
        end
    end

    assign stop_dis = dis_q;
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      halt_req,
    input  logic      stop_req,
    input  logic      irq,
    input  logic      wdt_expire,
    input  logic      stop_dis,
    input  logic      settle_done,
    output pm_state_t state,
    output logic      stop_wake,
    output logic      resume_pulse,
    output logic      restart_pulse
);
    pm_state_t state_q, state_d;
    pm_cause_t cause_q, cause_d;
    logic      resume_q, resume_d;
    logic      restart_q, restart_d;

    always_comb begin
        state_d   = state_q;
        cause_d   = cause_q;
        resume_d  = 1'b0;
        restart_d = 1'b0;
        stop_wake = 1'b0;
        case (state_q)
            ST_BOOT: begin
                if (settle_done) begin
                    state_d   = ST_RUN;
                    restart_d = 1'b1;
                end
            end
            ST_RUN: begin
                if (wdt_expire) begin
                    restart_d = 1'b1;
                end else if (halt_req) begin
                    state_d = ST_HALT;
                end else if (stop_req && !stop_dis) begin
                    state_d = ST_STOP;
                end
            end
            ST_HALT: begin
                if (wdt_expire) begin
                    state_d   = ST_RUN;
                    restart_d = 1'b1;
                end else if (irq) begin
                    state_d  = ST_RUN;
                    resume_d = 1'b1;
                end
            end
            ST_STOP: begin
                if (wdt_expire || irq) begin
                    state_d   = ST_WAKE;
                    stop_wake = 1'b1;
                    cause_d   = wdt_expire ? CAUSE_WDT : CAUSE_IRQ;
                end
            end
            ST_WAKE: begin
                if (settle_done) begin
                    state_d   = ST_RUN;
                    resume_d  = (cause_q == CAUSE_IRQ);
                    restart_d = (cause_q != CAUSE_IRQ);
                end
            end
            default: state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_BOOT;
            cause_q   <= CAUSE_RST;
            resume_q  <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cause_q   <= cause_d;
            resume_q  <= resume_d;
            restart_q <= restart_d;
        end
    end

    assign state         = state_q;
    assign resume_pulse  = resume_q;
    assign restart_pulse = restart_q;
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
    import pm_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16,
    parameter int WIN_CYCLES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_req,
    input  logic       stop_req,
    input  logic       irq,
    input  logic       wdt_expire,
    input  logic       cfg_wr,
    input  logic       cfg_stop_dis,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic [1:0] mode,
    output logic       resume_next,
    output logic       restart_vec
);
    pm_state_t state;
    pm_outs_t  outs;
    logic      stop_dis;
    logic      stop_wake;
    logic      settle_done;

    pm_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .counting (is_settling(state)),
        .done     (settle_done)
    );

    pm_stop_cfg #(.WIN_CYCLES(WIN_CYCLES)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .run_en    (outs.cpu_clk_en),
        .cfg_wr    (cfg_wr),
        .cfg_val   (cfg_stop_dis),
        .stop_wake (stop_wake),
        .stop_dis  (stop_dis)
    );

    pm_mode_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .halt_req      (halt_req),
        .stop_req      (stop_req),
        .irq           (irq),
        .wdt_expire    (wdt_expire),
        .stop_dis      (stop_dis),
        .settle_done   (settle_done),
        .state         (state),
        .stop_wake     (stop_wake),
        .resume_pulse  (resume_next),
        .restart_pulse (restart_vec)
    );

    assign outs       = decode_state(state);
    assign cpu_clk_en = outs.cpu_clk_en;
    assign osc_en     = outs.osc_en;
    assign mode       = outs.mode;
endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       halt_req,
    input logic       stop_req,
    input logic       wdt_expire,
    input logic       stop_dis,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic [1:0] mode,
    input logic       resume_next,
    input logic       restart_vec
);
    assert_no_cpu_without_osc_R12: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> !cpu_clk_en);

    assert_mode_legal_R12: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);

    assert_pulse_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(resume_next && restart_vec));

    assert_resume_with_clock_R3: assert property (@(posedge clk) disable iff (rst)
        resume_next |-> cpu_clk_en);

    assert_settle_after_stop_R8: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> !cpu_clk_en);

    assert_halt_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && halt_req && !wdt_expire) |=> (mode == 2'b01 && !cpu_clk_en && osc_en));

    assert_stop_noop_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && stop_req && !halt_req && !wdt_expire && stop_dis) |=> cpu_clk_en);

    assert_wake_rearm_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |-> stop_dis);

    assert_wdt_run_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && wdt_expire) |=> (cpu_clk_en && restart_vec));
endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .halt_req    (halt_req),
    .stop_req    (stop_req),
    .wdt_expire  (wdt_expire),
    .stop_dis    (stop_dis),
    .cpu_clk_en  (cpu_clk_en),
    .osc_en      (osc_en),
    .mode        (mode),
    .resume_next (resume_next),
    .restart_vec (restart_vec)
);

// File: tb/pwrmode_ctrl_tb.sv
`timescale 1ns/1ps
module pwrmode_ctrl_tb;
    localparam int SETTLE = 16;
    localparam int WIN    = 2;

    logic clk = 1'b0;
    logic rst, halt_req, stop_req, irq, wdt_expire, cfg_wr, cfg_stop_dis;
    logic cpu_clk_en, osc_en, resume_next, restart_vec;
    logic [1:0] mode;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwrmode_ctrl #(.SETTLE_CYCLES(SETTLE), .WIN_CYCLES(WIN)) u_dut (
        .clk(clk), .rst(rst), .halt_req(halt_req), .stop_req(stop_req),
        .irq(irq), .wdt_expire(wdt_expire), .cfg_wr(cfg_wr),
        .cfg_stop_dis(cfg_stop_dis), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .mode(mode), .resume_next(resume_next), .restart_vec(restart_vec)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic idle();
        halt_req = 0; stop_req = 0; irq = 0; wdt_expire = 0; cfg_wr = 0; cfg_stop_dis = 0;
    endtask

    // R1: reset state and boot settle time
    task automatic do_reset();
        int n;
        idle();
        rst = 1;
        cyc(3);
        chk("R1 osc_en in reset", osc_en, 1);
        chk("R1 cpu_clk_en in reset", cpu_clk_en, 0);
        chk("R1 mode in reset", mode, 0);
        rst = 0;
        n = 0;
        while (!cpu_clk_en && n < 100) begin cyc(); n++; end
        chk("R1 boot settle edges", n, SETTLE);
        chk("R1 restart_vec on boot", restart_vec, 1);
        chk("R1 resume_next on boot", resume_next, 0);
    endtask

    task automatic open_stop();
        do_reset();
        cfg_wr = 1; cfg_stop_dis = 0;
        cyc();
        idle();
    endtask

    task automatic t_halt_irq();
        do_reset();
        cyc(2);
        halt_req = 1; stop_req = 1;
        cyc(); idle();
        chk("R2 halt mode", mode, 1);
        chk("R2 halt cpu_clk_en", cpu_clk_en, 0);
        chk("R2 halt osc_en", osc_en, 1);
        stop_req = 1;
        cyc(); idle();
        chk("R11 stop_req ignored in halt", mode, 1);
        cyc(3);
        chk("R2 halt held", mode, 1);
        irq = 1;
        cyc(); idle();
        chk("R3 irq exit mode", mode, 0);
        chk("R3 irq exit clk", cpu_clk_en, 1);
        chk("R3 resume_next", resume_next, 1);
        chk("R3 restart_vec low", restart_vec, 0);
        cyc();
        chk("R3 resume one cycle", resume_next, 0);
    endtask

    task automatic t_halt_wdt();
        do_reset();
        halt_req = 1;
        cyc(); idle();
        irq = 1; wdt_expire = 1;
        cyc(); idle();
        chk("R4 wdt exit clk", cpu_clk_en, 1);
        chk("R4 restart_vec", restart_vec, 1);
        chk("R4 resume_next low", resume_next, 0);
    endtask

    task automatic t_run_wdt();
        do_reset();
        cyc(2);
        wdt_expire = 1;
        cyc(); idle();
        chk("R10 wdt in run clk", cpu_clk_en, 1);
        chk("R10 wdt in run restart", restart_vec, 1);
        chk("R10 wdt in run mode", mode, 0);
    endtask

    task automatic t_stop_default();
        do_reset();
        cyc(2);
        stop_req = 1;
        cyc(); idle();
        chk("R5 stop no-op mode", mode, 0);
        chk("R5 stop no-op clk", cpu_clk_en, 1);
        chk("R5 stop no-op osc", osc_en, 1);
    endtask

    task automatic t_late_write();
        do_reset();
        cyc(WIN + 3);
        cfg_wr = 1; cfg_stop_dis = 0;
        cyc(); idle();
        stop_req = 1;
        cyc(); idle();
        chk("R6 late write ignored", mode, 0);
        chk("R6 late write ignored clk", cpu_clk_en, 1);
    endtask

    task automatic t_stop_wake(bit use_wdt);
        int n;
        open_stop();
        cyc();
        stop_req = 1;
        cyc(); idle();
        chk("R7 stop mode", mode, 2);
        chk("R7 stop osc_en", osc_en, 0);
        chk("R7 stop cpu_clk_en", cpu_clk_en, 0);
        halt_req = 1; cfg_wr = 1; cfg_stop_dis = 1;
        cyc(); idle();
        chk("R11 halt_req ignored in stop", mode, 2);
        cyc(3);
        chk("R7 stop held osc", osc_en, 0);
        if (use_wdt) begin irq = 1; wdt_expire = 1; end else irq = 1;
        cyc(); idle();
        chk("R8 osc back", osc_en, 1);
        chk("R8 mode during settle", mode, 2);
        chk("R8 clk off during settle", cpu_clk_en, 0);
        n = 0;
        while (!cpu_clk_en && n < 100) begin cyc(); n++; end
        chk("R8 wake settle edges", n, SETTLE);
        chk("R8 mode after wake", mode, 0);
        chk("R8 resume_next", resume_next, use_wdt ? 0 : 1);
        chk("R8 restart_vec", restart_vec, use_wdt ? 1 : 0);
        cyc();
        stop_req = 1;
        cyc(); idle();
        chk("R9 stop re-disabled mode", mode, 0);
        chk("R9 stop re-disabled osc", osc_en, 1);
    endtask

    initial begin
        rst = 1;
        idle();
        t_halt_irq();
        t_halt_wdt();
        t_run_wdt();
        t_stop_default();
        t_late_write();
        t_stop_wake(0);
        t_stop_wake(1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule